// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register holding the resolved directions of the most recent branches. That history pattern is XORed with the fetch address bits of the branch to pick one two-bit saturating counter from a small table. The upper bit of the chosen counter is the guess. Distinct branches, or distinct histories, that hash to the same slot share one counter on purpose. This keeps the table small at the cost of some interference.

The front end presents the branch address bits every cycle and reads back a direction and the slot index. It keeps that index with the branch. When the branch resolves, the back end returns the saved index and the real outcome. The counter in that slot then moves one step toward the outcome, and the outcome is shifted into the history. After a misprediction the front end can overwrite the history with a snapshot it saved earlier.

The caller supplies the address bits directly above the instruction alignment bits. These are `HIST_W` bits, for example bits [7:2] of a 32-bit PC for the default width.

Top module: `gh_dir_pred`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and the history is all zeros, so `pred_idx` equals `pred_pc_bits` and `pred_taken` is 0 for any address.
- R2: `pred_idx` equals the current history XOR `pred_pc_bits`, combinationally in the same cycle.
- R3: An update with `upd_taken`=1 raises the counter at `upd_idx` by one at the next clock edge and holds it at 11 once it is there.
- R4: An update with `upd_taken`=0 lowers the counter at `upd_idx` by one at the next clock edge and holds it at 00 once it is there.
- R5: `pred_taken` is the most significant bit of the selected counter: 1 for counter values 10 and 11, 0 for 00 and 01.
- R6: On an update without flush, the history shifts left by one at the next edge. The resolved outcome enters bit 0 and bit `HIST_W`-1 is dropped.
- R7: When `flush` is 1, the history is loaded with `flush_hist` at the next edge. This takes priority over a shift from an update in the same cycle, and the counter update in that cycle still happens.
- R8: When a prediction and an update select the same slot in one cycle, the prediction shows the value from before the update. The updated value is seen from the next cycle on.
- R9: An update changes only the slot at `upd_idx`. Two different addresses whose hash lands on the same slot read the same shared counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc_bits | input | HIST_W | Branch address bits above the alignment bits |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | HIST_W | Table slot used for this prediction |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_idx | input | HIST_W | Slot index saved at prediction time |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| flush | input | 1 | Restore the history from `flush_hist` |
| flush_hist | input | HIST_W | History snapshot to restore |

## Verification
The prediction outputs are combinational. They are due in the same cycle the address is applied, and they reflect all counter and history changes clocked in at earlier edges. An update or a flush reaches the state one edge later. The next cycle's prediction is therefore the first one that can show it. The bench drives inputs on the falling edge, queues the value expected from its own model of the state before the coming rising edge, and compares one time unit later, still ahead of that rising edge. The model is advanced only after each expectation has been queued. This reproduces the rule that a prediction sees state from before the update in the same cycle.

// File: rtl/gh_dir_pred_pkg.sv
package gh_dir_pred_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX  = '1;
  localparam ctr_t CTR_MIN  = '0;
  localparam ctr_t CTR_INIT = ctr_t'(1);

  // One saturating step toward the resolved direction
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken && cur != CTR_MAX) nxt = cur + ctr_t'(1);
    if (!taken && cur != CTR_MIN) nxt = cur - ctr_t'(1);
    return nxt;
  endfunction

  // Direction read from a counter: its upper half means taken
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[CTR_W-1];
  endfunction
endpackage

// File: rtl/gh_hist_reg.sv
module gh_hist_reg #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              load_en,
  input  logic [HIST_W-1:0] load_val,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_shifted;

  generate
    if (HIST_W > 1) begin : g_wide
      assign hist_shifted = {hist_q[HIST_W-2:0], shift_bit};
    end else begin : g_one
      assign hist_shifted = shift_bit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (load_en)  hist_q <= load_val;
    else if (shift_en) hist_q <= hist_shifted;
  end

  assign hist = hist_q;
endmodule

// File: rtl/gh_ctr_table.sv
module gh_ctr_table
  import gh_dir_pred_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output ctr_t             wr_old,
  output ctr_t             wr_new
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];

  assign rd_val = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_taken);

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ctr_q[e] <= CTR_INIT;
        else if (wr_en && wr_idx == IDX_W'(e))
          ctr_q[e] <= wr_new;
      end
    end
  endgenerate
endmodule

// File: rtl/gh_dir_pred.sv
module gh_dir_pred
  import gh_dir_pred_pkg::*;
#(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] pred_pc_bits,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_idx,
  input  logic              upd_valid,
  input  logic [HIST_W-1:0] upd_idx,
  input  logic              upd_taken,
  input  logic              flush,
  input  logic [HIST_W-1:0] flush_hist
);
  localparam int IDX_W = HIST_W;

  // Named internal events for the checker
  logic [HIST_W-1:0] hist_now;
  logic [IDX_W-1:0]  hash_idx;
  ctr_t              pred_ctr;
  ctr_t              upd_ctr_old;
  ctr_t              upd_ctr_new;

  gh_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .shift_bit(upd_taken),
    .load_en  (flush),
    .load_val (flush_hist),
    .hist     (hist_now)
  );

  assign hash_idx = IDX_W'(hist_now ^ pred_pc_bits);

  gh_ctr_table #(.IDX_W(IDX_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (hash_idx),
    .rd_val  (pred_ctr),
    .wr_en   (upd_valid),
    .wr_idx  (upd_idx),
    .wr_taken(upd_taken),
    .wr_old  (upd_ctr_old),
    .wr_new  (upd_ctr_new)
  );

  assign pred_idx   = hash_idx;
  assign pred_taken = ctr_dir(pred_ctr);
endmodule

// File: rtl/gh_dir_pred_chk.sv
module gh_dir_pred_chk
  import gh_dir_pred_pkg::*;
#(
  parameter int HIST_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic              flush,
  input logic [HIST_W-1:0] flush_hist,
  input logic [HIST_W-1:0] hist_now,
  input logic [HIST_W-1:0] pred_pc_bits,
  input logic [HIST_W-1:0] pred_idx,
  input ctr_t              upd_ctr_old,
  input ctr_t              upd_ctr_new
);
  // R3: taken moves up by one or stays at the top
  assert_taken_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |->
      ((upd_ctr_old == CTR_MAX) ? (upd_ctr_new == CTR_MAX)
                                : (upd_ctr_new == upd_ctr_old + ctr_t'(1))));

  // R4: not-taken moves down by one or stays at zero
  assert_nottaken_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |->
      ((upd_ctr_old == CTR_MIN) ? (upd_ctr_new == CTR_MIN)
                                : (upd_ctr_new == upd_ctr_old - ctr_t'(1))));

  // R6: outcome shifted into bit 0 one edge later
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !flush) |=> (hist_now[0] == $past(upd_taken)));

  // R7: flush loads the snapshot, winning over a shift
  assert_flush_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (hist_now == $past(flush_hist)));

  // R6/R7: history is frozen without update or flush
  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !flush) |=> $stable(hist_now));

  // R2: index is the XOR of history and address bits
  assert_index_hash_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pred_idx ^ hist_now) == pred_pc_bits));
endmodule

bind gh_dir_pred gh_dir_pred_chk #(.HIST_W(HIST_W)) u_chk (.*);

// File: tb/test_gh_dir_pred.sv
module test_gh_dir_pred;
  localparam int HW = 6;
  localparam int N  = 1 << HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] pred_pc_bits = '0;
  logic          pred_taken;
  logic [HW-1:0] pred_idx;
  logic          upd_valid = 1'b0;
  logic [HW-1:0] upd_idx = '0;
  logic          upd_taken = 1'b0;
  logic          flush = 1'b0;
  logic [HW-1:0] flush_hist = '0;

  always #2 clk = ~clk;

  gh_dir_pred #(.HIST_W(HW)) i_gh_dir_pred (.*);

  // Reference state
  int            m_ctr [N];
  logic [HW-1:0] m_hist;

  // Scoreboard queues
  logic [HW:0] exp_q [$];
  string       tag_q [$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [HW-1:0] pc_slice(input logic [31:0] pc);
    return pc[HW+1:2];
  endfunction

  task automatic drive(input logic [31:0] pc, input logic uv,
                       input logic [HW-1:0] ui, input logic ut,
                       input logic fl, input logic [HW-1:0] fh,
                       input string tag);
    logic [HW-1:0] ix;
    @(negedge clk);
    pred_pc_bits = pc_slice(pc);
    upd_valid = uv; upd_idx = ui; upd_taken = ut;
    flush = fl; flush_hist = fh;
    ix = m_hist ^ pc_slice(pc);
    exp_q.push_back({(m_ctr[ix] >= 2), ix});
    tag_q.push_back(tag);
    // advance the model to what the coming edge produces
    if (uv) begin
      if (ut) m_ctr[ui] = (m_ctr[ui] == 3) ? 3 : m_ctr[ui] + 1;
      else    m_ctr[ui] = (m_ctr[ui] == 0) ? 0 : m_ctr[ui] - 1;
    end
    if (fl)      m_hist = fh;
    else if (uv) m_hist = {m_hist[HW-2:0], ut};
  endtask

  task automatic idle_pred(input logic [31:0] pc, input string tag);
    drive(pc, 1'b0, '0, 1'b0, 1'b0, '0, tag);
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [HW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({pred_taken, pred_idx} !== e) begin
          n_fail++;
          $display("FAIL %s: taken/idx actual %b/%0d expected %b/%0d",
                   t, pred_taken, pred_idx, e[HW], e[HW-1:0]);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_ctr[i] = 1;
    m_hist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, several addresses
    idle_pred(32'h0000_0100, "R1");
    idle_pred(32'h0000_00fc, "R1");
    idle_pred(32'h1234_5678, "R1");

    // R3: train slot 5 taken three times, saturate at 11 (R5 at 10/11)
    drive(32'h0, 1'b1, 6'd5, 1'b1, 1'b1, 6'd0, "R3");
    drive(32'h0, 1'b1, 6'd5, 1'b1, 1'b1, 6'd0, "R3");
    drive(32'h0, 1'b1, 6'd5, 1'b1, 1'b1, 6'd0, "R3");
    idle_pred(32'h0000_0014, "R5");   // slice 5, hist 0
    // R4: drive slot 5 down to 00 and past it
    for (int k = 0; k < 4; k++)
      drive(32'h0000_0014, 1'b1, 6'd5, 1'b0, 1'b1, 6'd0, "R4");
    idle_pred(32'h0000_0014, "R4");
    drive(32'h0000_0014, 1'b1, 6'd5, 1'b1, 1'b1, 6'd0, "R4");
    idle_pred(32'h0000_0014, "R5");

    // R6: history shifts with outcomes, visible in pred_idx
    drive(32'h0, 1'b1, 6'd40, 1'b1, 1'b0, 6'd0, "R6");
    drive(32'h0, 1'b1, 6'd40, 1'b0, 1'b0, 6'd0, "R6");
    drive(32'h0, 1'b1, 6'd40, 1'b1, 1'b0, 6'd0, "R6");
    idle_pred(32'h0000_0000, "R6");
    for (int k = 0; k < 6; k++)
      drive(32'h0000_0040, 1'b1, 6'd41, 1'b1, 1'b0, 6'd0, "R6");
    idle_pred(32'h0000_0088, "R2");

    // R7: flush wins over a simultaneous update shift
    drive(32'h0, 1'b1, 6'd9, 1'b1, 1'b1, 6'b101010, "R7");
    idle_pred(32'h0000_0004, "R7");
    drive(32'h0, 1'b0, 6'd0, 1'b0, 1'b1, 6'b000111, "R7");
    idle_pred(32'h0000_00f0, "R2");

    // R8: predict and update the same slot in one cycle
    drive(32'h0, 1'b0, 6'd0, 1'b0, 1'b1, 6'd0, "R8");
    drive(32'h0000_0030, 1'b1, 6'd12, 1'b1, 1'b1, 6'd0, "R8");
    drive(32'h0000_0030, 1'b1, 6'd12, 1'b1, 1'b1, 6'd0, "R8");
    drive(32'h0000_0030, 1'b0, 6'd0, 1'b0, 1'b1, 6'd0, "R8");

    // R9: aliasing - different address/history pairs share slot 12
    drive(32'h0, 1'b0, 6'd0, 1'b0, 1'b1, 6'd3, "R9");
    idle_pred(32'h0000_003c, "R9");   // 3 ^ 15 = 12
    idle_pred(32'h0000_0034, "R9");   // 3 ^ 13 = 14, untouched
    drive(32'h0, 1'b0, 6'd0, 1'b0, 1'b1, 6'd0, "R9");
    idle_pred(32'h0000_0038, "R9");   // slot 14 still 01
    idle_pred(32'h0000_0024, "R9");   // slot 9 trained once

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule